// File: doc/BRIEF.md
# Delayed-Reply SPI Host Transaction Engine

This block is the host side of a serial link to a sensor that answers one frame late. Each link frame is 32 bits, shifted most-significant bit first in SPI mode 0 (clock idles low, data sampled on the rising edge, changed on the falling edge). To read, the host sends a request frame. It raises chip select for a programmable gap, then clocks a second frame. During that second frame it sends zeros and collects the sensor's answer. To write, it sends one frame that carries both address and data, and no answer is collected. Every frame carries a 3-bit CRC in its lowest bits.

The host presents a request on a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until every frame of the transaction has ended and the chip-select gap has elapsed, so a held `req_valid` is back-pressured without loss. The result comes back as a one-cycle `rsp_valid` pulse with `rsp_rdata` and `rsp_err`. The result side has no back-pressure: the consumer must take it in that cycle.

The SPI clock half-period (`CLK_DIV` system cycles) and the minimum chip-select-high gap (`GAP_CYCLES` system cycles) are parameters.

Top module: `late_reply_spi_host`

## Requirements
- R1: A request frame has bits 31:30 zero, bits 29:22 the address, bit 21 set for a write, bit 20 the capture input, and bit 19 zero. Bits 18:3 carry the write data on a write and are zero on a read.
- R2: Bits 2:0 of every request frame hold a 3-bit CRC over the frame with those bits taken as zero. The CRC register starts at 3'b101 and takes frame bits MSB first. At each step, bit 2 is noted, the register shifts left taking the next bit into bit 0, and it is XORed with 3'b011 when the noted bit was 1.
- R3: Frames are 32 SCLK rising edges long, MSB first, with SCLK low whenever chip select is high. MOSI does not change at a rising SCLK edge.
- R4: A read uses two frames: the request, then a frame in which MOSI is all zeros. `rsp_rdata` returns bits 19:4 of the word received in the second frame.
- R5: A write uses exactly one frame. Its result pulse carries `rsp_err` = 0 and `rsp_rdata` = 0.
- R6: A received word whose 32-bit CRC run (same rule as R2, over all 32 bits) does not end at zero is rejected: `rsp_err` = 1 and `rsp_rdata` = 0.
- R7: A received word with bit 31 and bit 3 both set is rejected in the same way even when its CRC is good. Either bit alone is accepted.
- R8: Between any two frames, including frames of different transactions, chip select stays high for at least `GAP_CYCLES` system clock cycles.
- R9: `req_ready` drops on the cycle after an accepted request and returns only after the transaction's result and gap. Each transaction yields exactly one single-cycle `rsp_valid` pulse.
- R10: After reset, chip select is high, SCLK is low, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can accept a request |
| req_addr | input | 8 | Register address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_capture | input | 1 | Capture flag placed in the request frame |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_rdata | output | 16 | Read data (0 on write or rejection) |
| rsp_err | output | 1 | Reply rejected |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Host-to-sensor data |
| spi_miso | input | 1 | Sensor-to-host data |

## Verification
The two events that meet are the result pulse of one transaction and the arrival of the next request. The bench keeps `req_valid` high back to back, so the next request is already waiting in the cycle the previous `rsp_valid` fires and while the gap counter is still running. The bench judges this by three checks. The waiting request must not be accepted early. Chip select must be measured high for at least `GAP_CYCLES` cycles before the next frame. The expected results, kept in order in a scoreboard, must come out one per transaction with nothing lost or repeated.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam int FRAME_W = 32;
  localparam int CRC_W   = 3;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;

  // field placement inside a frame (decoded by the far end)
  localparam int ADDR_LO = 22;
  localparam int ADDR_HI = ADDR_LO + ADDR_W - 1;
  localparam int WR_BIT  = 21;
  localparam int CAP_BIT = 20;
  localparam int WD_LO   = 3;
  localparam int WD_HI   = WD_LO + DATA_W - 1;
  localparam int RD_LO   = 4;
  localparam int RD_HI   = RD_LO + DATA_W - 1;
  localparam int HI_FLAG = 31;
  localparam int LO_FLAG = 3;

  localparam logic [CRC_W-1:0] CRC_SEED = 3'b101;
  localparam logic [CRC_W-1:0] CRC_TAPS = 3'b011;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_GAP, SQ_RSP} seq_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic              write;
    logic              capture;
  } host_req_t;

  function automatic logic [CRC_W-1:0] crc3_run(input logic [FRAME_W-1:0] word);
    logic [CRC_W-1:0] acc;
    logic             fb;
    acc = CRC_SEED;
    for (int i = FRAME_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1];
      acc = {acc[CRC_W-2:0], word[i]};
      if (fb) acc = acc ^ CRC_TAPS;
    end
    return acc;
  endfunction
endpackage

// File: rtl/lrs_frame_codec.sv
module lrs_frame_codec
  import lrs_pkg::*;
(
  input  host_req_t          req,
  output logic [FRAME_W-1:0] req_frame,
  input  logic [FRAME_W-1:0] rsp_word,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_bad
);
  logic [FRAME_W-1:0] body;
  logic               crc_fail;
  logic               flag_clash;

  // R1/R2: assemble fields, then fill the check bits
  always_comb begin
    body                  = '0;
    body[ADDR_HI:ADDR_LO] = req.addr;
    body[WR_BIT]          = req.write;
    body[CAP_BIT]         = req.capture;
    if (req.write) body[WD_HI:WD_LO] = req.wdata;
    req_frame             = body;
    req_frame[CRC_W-1:0]  = crc3_run(body);
  end

  // R6/R7: reply screening
  assign crc_fail   = crc3_run(rsp_word) != '0;
  assign flag_clash = rsp_word[HI_FLAG] & rsp_word[LO_FLAG];
  assign rsp_bad    = crc_fail | flag_clash;
  assign rsp_data   = rsp_bad ? '0 : rsp_word[RD_HI:RD_LO];
endmodule

// File: rtl/lrs_shifter.sv
module lrs_shifter
  import lrs_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               done,
  output logic [FRAME_W-1:0] rx_word,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam int BIT_W = $clog2(FRAME_W);

  logic               active;
  logic               sclk_q;
  logic [DIV_W-1:0]   div_cnt;
  logic [BIT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] tx_sr;
  logic [FRAME_W-1:0] rx_sr;
  logic               tick;

  assign tick = div_cnt == DIV_W'(CLK_DIV - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sclk_q  <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        div_cnt <= '0;
        sclk_q  <= 1'b0;
        if (start) begin
          active  <= 1'b1;
          tx_sr   <= tx_word;
          bit_cnt <= '0;
        end
      end else if (!tick) begin
        div_cnt <= div_cnt + DIV_W'(1);
      end else begin
        div_cnt <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_sr  <= {rx_sr[FRAME_W-2:0], miso};
        end else begin
          sclk_q <= 1'b0;
          if (bit_cnt == BIT_W'(FRAME_W - 1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + BIT_W'(1);
            tx_sr   <= {tx_sr[FRAME_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign cs_n    = ~active;
  assign sclk    = sclk_q;
  assign mosi    = active & tx_sr[FRAME_W-1];
  assign rx_word = rx_sr;

  a_r3_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r3_mosi_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));
endmodule

// File: rtl/lrs_sequencer.sv
module lrs_sequencer
  import lrs_pkg::*;
#(
  parameter int GAP_CYCLES = 176
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  output logic              req_ready,
  output logic              start,
  output logic              send_req,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_bad,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  localparam int GW = $clog2(GAP_CYCLES + 1);

  seq_state_e    state;
  logic [GW-1:0] gap_cnt;
  logic          wr_q;
  logic          accept;
  logic          gap_done;

  assign gap_done  = gap_cnt == '0;
  assign req_ready = (state == SQ_IDLE) && gap_done;
  assign accept    = req_valid && req_ready;
  assign send_req  = state == SQ_IDLE;
  assign start     = accept || ((state == SQ_GAP) && gap_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      gap_cnt   <= '0;
      wr_q      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (!gap_done) gap_cnt <= gap_cnt - GW'(1);
      unique case (state)
        SQ_IDLE: if (accept) begin
          wr_q  <= req_write;
          state <= SQ_REQ;
        end
        SQ_REQ: if (frame_done) begin
          gap_cnt <= GW'(GAP_CYCLES);
          if (wr_q) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
            state     <= SQ_IDLE;
          end else begin
            state <= SQ_GAP;
          end
        end
        SQ_GAP: if (gap_done) state <= SQ_RSP;
        SQ_RSP: if (frame_done) begin
          gap_cnt   <= GW'(GAP_CYCLES);
          rsp_valid <= 1'b1;
          rsp_rdata <= rsp_data;
          rsp_err   <= rsp_bad;
          state     <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  a_r9_single_cycle_result: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r5_write_result_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && wr_q) |-> (!rsp_err && rsp_rdata == '0));
endmodule

// File: rtl/late_reply_spi_host.sv
module late_reply_spi_host
  import lrs_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int GAP_CYCLES = 176
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_addr,
  input  logic [15:0] req_wdata,
  input  logic        req_write,
  input  logic        req_capture,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata,
  output logic        rsp_err,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int HW = $clog2(GAP_CYCLES + 2);

  host_req_t          req_s;
  logic [FRAME_W-1:0] req_frame;
  logic [FRAME_W-1:0] tx_word;
  logic [FRAME_W-1:0] rx_word;
  logic [DATA_W-1:0]  dec_data;
  logic               dec_bad;
  logic               start;
  logic               send_req;
  logic               frame_done;

  assign req_s   = '{addr: req_addr, wdata: req_wdata, write: req_write, capture: req_capture};
  assign tx_word = send_req ? req_frame : '0;  // R4: reply frame clocks zeros

  lrs_frame_codec u_codec (
    .req       (req_s),
    .req_frame (req_frame),
    .rsp_word  (rx_word),
    .rsp_data  (dec_data),
    .rsp_bad   (dec_bad)
  );

  lrs_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tx_word (tx_word),
    .done    (frame_done),
    .rx_word (rx_word),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .miso    (spi_miso)
  );

  lrs_sequencer #(.GAP_CYCLES(GAP_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .start      (start),
    .send_req   (send_req),
    .frame_done (frame_done),
    .rsp_data   (dec_data),
    .rsp_bad    (dec_bad),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err)
  );

  // R8 watch: cycles chip select has been high since the last frame
  logic [HW-1:0] hi_cnt;
  logic          seen_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt     <= '0;
      seen_frame <= 1'b0;
    end else if (spi_cs_n) begin
      if (hi_cnt != HW'(GAP_CYCLES + 1)) hi_cnt <= hi_cnt + HW'(1);
    end else begin
      hi_cnt     <= '0;
      seen_frame <= 1'b1;
    end
  end

  a_r8_cs_gap_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(spi_cs_n) && seen_frame) |-> (hi_cnt >= HW'(GAP_CYCLES)));
endmodule

// File: tb/tb_late_reply_spi_host.sv
`timescale 1ns/1ps
module tb_late_reply_spi_host;
  localparam int CLK_DIV = 4;
  localparam int GAP     = 176;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_write = 1'b0;
  logic        req_capture = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        rsp_err;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  late_reply_spi_host #(.CLK_DIV(CLK_DIV), .GAP_CYCLES(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_capture(req_capture), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int errors = 0;
  int txns = 0;
  int results = 0;
  bit finished = 0;

  logic [31:0] exp_frame_q[$];
  logic [31:0] reply_q[$];
  logic [15:0] exp_data_q[$];
  logic        exp_err_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_crc(input logic [31:0] w);
    logic [2:0] r;
    bit t;
    r = 3'b101;
    for (int k = 31; k >= 0; k--) begin
      t = r[2];
      r = {r[1:0], w[k]};
      if (t) r = r ^ 3'b011;
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_request(input logic [7:0] a, input logic [15:0] d,
                                              input bit wr, input bit cap);
    logic [31:0] f;
    f = 32'(a) << 22;
    f[21] = wr;
    f[20] = cap;
    if (wr) f = f | (32'(d) << 3);
    f[2:0] = ref_crc(f);
    return f;
  endfunction

  // ---- SPI sensor model -------------------------------------------------
  logic [31:0] rep_w = '0;
  logic [31:0] cap_w = '0;
  int          sbit = 0;
  int          rises = 0;
  bit          frame_open = 0;

  always @(negedge spi_cs_n) begin
    rep_w = (reply_q.size() != 0) ? reply_q.pop_front() : 32'h0;
    sbit = 31;
    spi_miso = rep_w[31];
    cap_w = '0;
    rises = 0;
    frame_open = 1;
  end
  always @(posedge spi_sclk) if (frame_open) begin
    cap_w = {cap_w[30:0], spi_mosi};
    rises++;
  end
  always @(negedge spi_sclk) if (frame_open && sbit > 0) begin
    sbit--;
    spi_miso = rep_w[sbit];
  end
  always @(posedge spi_cs_n) if (frame_open) begin
    logic [31:0] e;
    frame_open = 0;
    check(rises == 32, "R3", "rising edges per frame", rises, 32);
    check(spi_sclk == 1'b0, "R3", "sclk low at deselect", spi_sclk, 0);
    if (exp_frame_q.size() == 0) begin
      check(0, "R5", "unexpected extra frame", cap_w, 0);
    end else begin
      e = exp_frame_q.pop_front();
      check(cap_w == e, "R1 R2 R4", "frame on MOSI", cap_w, e);
    end
  end

  // ---- R8 gap monitor ---------------------------------------------------
  int  hi_run = 0;
  bit  had_frame = 0;
  logic cs_prev = 1'b1;
  always @(negedge clk) if (rst_n) begin
    if (cs_prev && !spi_cs_n && had_frame)
      check(hi_run >= GAP, "R8", "cs high cycles", hi_run, GAP);
    if (!spi_cs_n) begin had_frame = 1; hi_run = 0; end
    else hi_run++;
    cs_prev = spi_cs_n;
  end

  // ---- scoreboard monitor -----------------------------------------------
  always @(negedge clk) if (rst_n && rsp_valid) begin
    results++;
    if (exp_data_q.size() == 0) begin
      check(0, "R9", "result without transaction", rsp_rdata, 0);
    end else begin
      logic [15:0] ed;
      logic        ee;
      ed = exp_data_q.pop_front();
      ee = exp_err_q.pop_front();
      check(rsp_err == ee, "R5 R6 R7", "rsp_err", rsp_err, ee);
      check(rsp_rdata == ed, "R4 R5 R6", "rsp_rdata", rsp_rdata, ed);
    end
  end

  // ---- driver -----------------------------------------------------------
  task automatic issue(input logic [7:0] a, input logic [15:0] d, input bit wr, input bit cap);
    req_valid = 1'b1; req_addr = a; req_wdata = d; req_write = wr; req_capture = cap;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    check(req_ready == 1'b0, "R9", "ready after accept", req_ready, 0);
    txns++;
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d, input bit cap);
    exp_frame_q.push_back(ref_request(a, d, 1'b1, cap));
    reply_q.push_back(32'h0);
    exp_data_q.push_back(16'h0);
    exp_err_q.push_back(1'b0);
    issue(a, d, 1'b1, cap);
  endtask

  task automatic do_read(input logic [7:0] a, input bit cap, input logic [15:0] d,
                         input bit hi, input bit lo, input bit corrupt);
    logic [31:0] w;
    bit bad;
    w = 32'(d) << 4;
    w[31] = hi;
    w[3] = lo;
    for (int c = 0; c < 8; c++)
      if (ref_crc({w[31:3], 3'(c)}) == 3'b000) w[2:0] = 3'(c);
    if (corrupt) w[9] = ~w[9];
    bad = corrupt || (hi && lo);
    exp_frame_q.push_back(ref_request(a, 16'h0, 1'b0, cap));
    exp_frame_q.push_back(32'h0);
    reply_q.push_back(32'h0);
    reply_q.push_back(w);
    exp_data_q.push_back(bad ? 16'h0 : d);
    exp_err_q.push_back(bad);
    issue(a, 16'h0, 1'b0, cap);
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_data_q.size() != 0 || exp_frame_q.size() != 0) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(spi_cs_n == 1'b1, "R10", "cs_n after reset", spi_cs_n, 1);
    check(spi_sclk == 1'b0, "R10", "sclk after reset", spi_sclk, 0);
    check(rsp_valid == 1'b0, "R10", "rsp_valid after reset", rsp_valid, 0);
    check(req_ready == 1'b1, "R10", "req_ready after reset", req_ready, 1);

    do_write(8'h2F, 16'h00B6, 1'b0);            // R5 single frame
    drain();
    do_write(8'hFF, 16'hFFFF, 1'b1);            // R1 all-ones fields
    drain();
    do_read(8'h00, 1'b0, 16'h0024, 0, 0, 0);    // R4 plain read
    drain();
    do_read(8'h17, 1'b1, 16'h8001, 0, 0, 0);    // R1 capture on read
    drain();
    do_read(8'h11, 1'b0, 16'h5A5A, 0, 0, 1);    // R6 bad CRC
    drain();
    do_read(8'h14, 1'b0, 16'h1234, 1, 1, 0);    // R7 both flags
    drain();
    do_read(8'h15, 1'b0, 16'hFFFF, 1, 0, 0);    // R7 high flag alone accepted
    drain();
    do_read(8'h16, 1'b0, 16'h0001, 0, 1, 0);    // R7 low flag alone accepted
    drain();

    // R8/R9 back-to-back: next request waits while result and gap occur
    do_read(8'h10, 1'b0, 16'hC3C3, 0, 0, 0);
    do_write(8'h0A, 16'h0039, 1'b0);
    do_read(8'h12, 1'b1, 16'h7FFE, 0, 0, 0);
    do_read(8'h13, 1'b0, 16'h0F0F, 0, 0, 1);
    do_write(8'h2F, 16'h00B6, 1'b1);
    drain();

    check(results == txns, "R9", "one result per transaction", results, txns);
    check(exp_frame_q.size() == 0, "R4", "all frames seen", exp_frame_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule